// File: doc/BRIEF.md
# Folded-Edge Long-Wire Hop Walker

The walker traces one long routing wire across a rectangular tile array of (m+1) columns by (n+1) rows. Each hop spans six tiles, with a tap point three tiles along. When a hop would leave the array it bounces off the edge: the coordinate is mirrored back inside and the direction of travel flips. The wire stays on the same axis and keeps its six-tile span.

A command gives the walker a start tile, a direction and the two grid limits. The walker then takes one hop per clock. After each hop it shows the tap tile, the landing tile, the current direction and the number of hops taken so far. It stops when the wire lands on its start tile again, which means the loop is closed. It also stops when its hop budget runs out, or when it is told to abort.

At start the walker also reports a prediction. This is the number of passes a wire on that axis needs before the loop closes. It is 3 when twice the axis limit minus four is not a multiple of six, and 1 otherwise. A test planner can use these closure points and counts to lay out closed wire loops on the array.

Top module: `hop_walker`

## Requirements
- R1: After reset, `busy`, `closed` and `err` are 0, and `hop_cnt`, `rounds`, every tile output and `dir` are 0.
- R2: A hop that stays inside the array moves the landing coordinate 6 tiles and the tap coordinate 3 tiles along the direction of travel. The coordinate on the other axis stays unchanged and the direction is kept.
- R3: Moving toward index 0 (left or down) from index p: the landing index is p-6 when p>5, else 5-p. The tap index is p-3 when p>2, else 2-p.
- R4: Moving toward the limit L (right with L=m, up with L=n) from index p: the landing index is p+6 when p<L-5, else 2L-p-5. The tap index is p+3 when p<L-2, else 2L-p-2.
- R5: Direction code 2'b00 is left, 2'b01 is right, 2'b10 is down and 2'b11 is up. A hop whose landing index is mirrored flips bit 0 of `dir`, and bit 1 never changes during a walk.
- R6: `start` is accepted while the walker is idle. In the next cycle `busy`=1 and `hop_cnt`=0, and `hop_cnt` then rises by one per clock, one hop each clock.
- R7: On the hop whose landing tile equals the start tile, `closed` goes to 1 and `busy` goes to 0. `hop_cnt` then holds the number of hops in the closed loop, and the landing outputs show the start tile.
- R8: `rounds` is loaded at start from the axis limit L of the start direction. It is 1 when (2L-4) mod 6 is 0, and 3 otherwise.
- R9: A `start` pulse while `busy` is 1 has no effect on the walk in progress.
- R10: `abort` while busy ends the walk in the next cycle with `closed`=0 and `err`=0, and `hop_cnt` frozen.
- R11: If `hop_cnt` reaches `hop_limit` without a closure, `err` goes to 1, `busy` goes to 0 and `hop_cnt` equals `hop_limit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, taken when idle |
| abort | input | 1 | Stop the current walk |
| start_col | input | 8 | Start column i |
| start_row | input | 8 | Start row j |
| start_dir | input | 2 | Start direction (R5 encoding) |
| lim_m | input | 8 | Highest column index m |
| lim_n | input | 8 | Highest row index n |
| hop_limit | input | 16 | Hop budget before error |
| busy | output | 1 | Walk in progress |
| closed | output | 1 | Last walk closed its loop |
| err | output | 1 | Last walk ran out of budget |
| dir | output | 2 | Current direction of travel |
| mid_col | output | 8 | Tap tile column of the last hop |
| mid_row | output | 8 | Tap tile row of the last hop |
| end_col | output | 8 | Landing tile column of the last hop |
| end_row | output | 8 | Landing tile row of the last hop |
| hop_cnt | output | 16 | Hops taken in this walk |
| rounds | output | 2 | Predicted passes to close |

## Verification
The properties assume three things about the inputs. `lim_m`, `lim_n` and `hop_limit` stay constant while `busy` is high. Each limit is at least 11. The start tile lies inside the array. Under these assumptions every mirrored index lands back inside the array, and the error check can compare `hop_cnt` with the live `hop_limit`. The stimulus changes the limits and the budget only between walks, always uses limits of 60 or more, and picks start tiles inside the grid. A stray `start` is sent only during a walk, to exercise R9.

// File: rtl/hop_walker_pkg.sv
package hop_walker_pkg;
    localparam int COORD_W = 8;
    localparam int INT_W   = 10;
    localparam int CNT_W   = 16;
    localparam int NAXIS   = 2;

    typedef logic [COORD_W-1:0] coord_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef enum logic [1:0] {
        DIR_LEFT  = 2'b00,
        DIR_RIGHT = 2'b01,
        DIR_DOWN  = 2'b10,
        DIR_UP    = 2'b11
    } dir_e;

    typedef struct packed {
        logic       busy;
        logic       closed;
        logic       err;
        logic [1:0] dir;
        coord_t     org_col;
        coord_t     org_row;
        coord_t     cur_col;
        coord_t     cur_row;
        coord_t     mid_col;
        coord_t     mid_row;
        coord_t     end_col;
        coord_t     end_row;
        cnt_t       cnt;
        logic [1:0] rounds;
    } walk_state_t;
endpackage

// File: rtl/hop_fold_unit.sv
module hop_fold_unit
    import hop_walker_pkg::*;
#(
    parameter int SPAN = 6
) (
    input  coord_t pos,
    input  coord_t lim,
    input  logic   to_high,
    output coord_t mid,
    output coord_t land,
    output logic   folded
);
    localparam int HALF = SPAN / 2;

    logic signed [INT_W-1:0] p_s, l_s, mid_s, land_s;

    always_comb begin
        p_s = signed'({{(INT_W-COORD_W){1'b0}}, pos});
        l_s = signed'({{(INT_W-COORD_W){1'b0}}, lim});
        if (to_high) begin
            if (p_s < l_s - INT_W'(HALF - 1)) mid_s = p_s + INT_W'(HALF);
            else                               mid_s = (l_s <<< 1) - p_s - INT_W'(HALF - 1);
            if (p_s < l_s - INT_W'(SPAN - 1)) begin
                land_s = p_s + INT_W'(SPAN);
                folded = 1'b0;
            end else begin
                land_s = (l_s <<< 1) - p_s - INT_W'(SPAN - 1);
                folded = 1'b1;
            end
        end else begin
            if (p_s > INT_W'(HALF - 1)) mid_s = p_s - INT_W'(HALF);
            else                         mid_s = INT_W'(HALF - 1) - p_s;
            if (p_s > INT_W'(SPAN - 1)) begin
                land_s = p_s - INT_W'(SPAN);
                folded = 1'b0;
            end else begin
                land_s = INT_W'(SPAN - 1) - p_s;
                folded = 1'b1;
            end
        end
        mid  = mid_s[COORD_W-1:0];
        land = land_s[COORD_W-1:0];
    end
endmodule

// File: rtl/hop_round_predict.sv
module hop_round_predict
    import hop_walker_pkg::*;
(
    input  coord_t     lim,
    output logic [1:0] rounds
);
    logic [INT_W-1:0] twice_plus;
    logic [INT_W-1:0] resid;

    always_comb begin
        // (2L - 4) mod 6 evaluated as (2L + 2) mod 6 to stay unsigned
        twice_plus = {1'b0, lim, 1'b0} + INT_W'(2);
        resid      = twice_plus % INT_W'(6);
        rounds     = (resid == '0) ? 2'd1 : 2'd3;
    end
endmodule

// File: rtl/hop_walker.sv
module hop_walker
    import hop_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [7:0]        start_col,
    input  logic [7:0]        start_row,
    input  logic [1:0]        start_dir,
    input  logic [7:0]        lim_m,
    input  logic [7:0]        lim_n,
    input  logic [15:0]       hop_limit,
    output logic              busy,
    output logic              closed,
    output logic              err,
    output logic [1:0]        dir,
    output logic [7:0]        mid_col,
    output logic [7:0]        mid_row,
    output logic [7:0]        end_col,
    output logic [7:0]        end_row,
    output logic [15:0]       hop_cnt,
    output logic [1:0]        rounds
);
    walk_state_t st_q, st_d;

    coord_t     ax_pos  [NAXIS];
    coord_t     ax_lim  [NAXIS];
    coord_t     ax_mid  [NAXIS];
    coord_t     ax_land [NAXIS];
    logic       ax_fold [NAXIS];
    logic [1:0] ax_rnd  [NAXIS];

    assign ax_pos[0] = st_q.cur_col;
    assign ax_pos[1] = st_q.cur_row;
    assign ax_lim[0] = lim_m;
    assign ax_lim[1] = lim_n;

    for (genvar g = 0; g < NAXIS; g++) begin : g_axis
        hop_fold_unit #(.SPAN(6)) u_fold (
            .pos    (ax_pos[g]),
            .lim    (ax_lim[g]),
            .to_high(st_q.dir[0]),
            .mid    (ax_mid[g]),
            .land   (ax_land[g]),
            .folded (ax_fold[g])
        );
        hop_round_predict u_rnd (
            .lim   (ax_lim[g]),
            .rounds(ax_rnd[g])
        );
    end

    logic   vert;
    coord_t nx_col, nx_row;
    cnt_t   nx_cnt;

    always_comb begin
        st_d   = st_q;
        vert   = st_q.dir[1];
        nx_col = st_q.cur_col;
        nx_row = st_q.cur_row;
        nx_cnt = st_q.cnt;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.closed  = 1'b0;
                st_d.err     = 1'b0;
                st_d.dir     = start_dir;
                st_d.org_col = start_col;
                st_d.org_row = start_row;
                st_d.cur_col = start_col;
                st_d.cur_row = start_row;
                st_d.mid_col = start_col;
                st_d.mid_row = start_row;
                st_d.end_col = start_col;
                st_d.end_row = start_row;
                st_d.cnt     = '0;
                st_d.rounds  = start_dir[1] ? ax_rnd[1] : ax_rnd[0];
            end
        end else if (abort) begin
            st_d.busy = 1'b0;
        end else begin
            if (vert) begin
                nx_row       = ax_land[1];
                st_d.mid_col = st_q.cur_col;
                st_d.mid_row = ax_mid[1];
                st_d.dir[0]  = st_q.dir[0] ^ ax_fold[1];
            end else begin
                nx_col       = ax_land[0];
                st_d.mid_col = ax_mid[0];
                st_d.mid_row = st_q.cur_row;
                st_d.dir[0]  = st_q.dir[0] ^ ax_fold[0];
            end
            st_d.end_col = nx_col;
            st_d.end_row = nx_row;
            st_d.cur_col = nx_col;
            st_d.cur_row = nx_row;
            if (st_q.cnt != {CNT_W{1'b1}}) nx_cnt = st_q.cnt + cnt_t'(1);
            st_d.cnt = nx_cnt;
            if (nx_col == st_q.org_col && nx_row == st_q.org_row) begin
                st_d.closed = 1'b1;
                st_d.busy   = 1'b0;
            end else if (nx_cnt >= hop_limit) begin
                st_d.err  = 1'b1;
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign closed  = st_q.closed;
    assign err     = st_q.err;
    assign dir     = st_q.dir;
    assign mid_col = st_q.mid_col;
    assign mid_row = st_q.mid_row;
    assign end_col = st_q.end_col;
    assign end_row = st_q.end_row;
    assign hop_cnt = st_q.cnt;
    assign rounds  = st_q.rounds;
endmodule

// File: rtl/hop_walker_chk.sv
module hop_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        abort,
    input logic [15:0] hop_limit,
    input logic        busy,
    input logic        closed,
    input logic        err,
    input logic [1:0]  dir,
    input logic [15:0] hop_cnt,
    input logic [1:0]  rounds
);
    p_first_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> hop_cnt == 16'd0);

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy && !abort) |-> hop_cnt == $past(hop_cnt) + 16'd1);

    p_axis_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> dir[1] == $past(dir[1]));

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(closed && err));

    p_close_ends_walk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(closed) |-> $fell(busy));

    p_rounds_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rounds == 2'd1 || rounds == 2'd3));

    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy && abort) |-> (!busy && !closed && !err));

    p_err_at_budget_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (hop_cnt == hop_limit && !busy));
endmodule

bind hop_walker hop_walker_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .hop_limit(hop_limit),
    .busy     (busy),
    .closed   (closed),
    .err      (err),
    .dir      (dir),
    .hop_cnt  (hop_cnt),
    .rounds   (rounds)
);

// File: tb/sim_hop_walker.sv
`timescale 1ns/1ps
module sim_hop_walker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0;
    logic [7:0] start_col = '0, start_row = '0, lim_m = 8'd60, lim_n = 8'd127;
    logic [1:0] start_dir = '0;
    logic [15:0] hop_limit = 16'hFFFF;
    logic busy, closed, err;
    logic [1:0] dir, rounds;
    logic [7:0] mid_col, mid_row, end_col, end_row;
    logic [15:0] hop_cnt;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hop_walker u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference from R3/R4: hops until the index returns to its start
    function automatic int ref_close(input int s, input bit hi0, input int lim);
        int p = s;
        bit hi = hi0;
        int k = 0;
        do begin
            if (hi) begin
                if (p < lim - 5) p = p + 6;
                else begin p = 2*lim - p - 5; hi = 1'b0; end
            end else begin
                if (p > 5) p = p - 6;
                else begin p = 5 - p; hi = 1'b1; end
            end
            k++;
        end while (p != s && k < 5000);
        return k;
    endfunction

    // returns at the negedge where busy=1 and hop_cnt=0
    task automatic launch(input int c, input int r, input logic [1:0] d);
        @(negedge clk);
        start_col = 8'(c); start_row = 8'(r); start_dir = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !closed && !err, "R1 flags", {busy, closed, err}, 0);
        chk(hop_cnt == 0 && rounds == 0 && dir == 0, "R1 count", hop_cnt, 0);
        chk(end_col == 0 && mid_row == 0, "R1 tiles", end_col, 0);
    endtask

    task automatic t_plain_hop();
        launch(20, 7, 2'b00);
        chk(busy && hop_cnt == 0, "R6 start", hop_cnt, 0);
        @(negedge clk);
        chk(mid_col == 17, "R2 mid", mid_col, 17);
        chk(end_col == 14 && end_row == 7, "R2 end", end_col, 14);
        chk(dir == 2'b00, "R2 dir kept", dir, 0);
        chk(hop_cnt == 1, "R6 step", hop_cnt, 1);
        @(negedge clk);
        chk(end_col == 8 && hop_cnt == 2, "R2 second hop", end_col, 8);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
    endtask

    task automatic t_low_fold();
        launch(2, 9, 2'b00);
        @(negedge clk);
        chk(mid_col == 0, "R3 mid fold", mid_col, 0);
        chk(end_col == 3, "R3 end fold", end_col, 3);
        chk(dir == 2'b01, "R5 reverse", dir, 1);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
    endtask

    task automatic t_high_fold();
        launch(58, 4, 2'b01);
        @(negedge clk);
        chk(mid_col == 60 && end_col == 57, "R4 right fold", end_col, 57);
        chk(dir == 2'b00, "R5 reverse right", dir, 0);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        launch(33, 125, 2'b11);
        @(negedge clk);
        chk(mid_row == 127 && end_row == 124, "R4 up fold", end_row, 124);
        chk(end_col == 33 && mid_col == 33, "R2 column kept", end_col, 33);
        chk(dir == 2'b10, "R5 reverse up", dir, 2);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
    endtask

    task automatic t_close(input int c, input int r, input logic [1:0] d,
                           input int lim, input int exp_rnd, input string tag);
        int exp_k;
        exp_k = ref_close(d[1] ? r : c, d[0], lim);
        launch(c, r, d);
        chk(rounds == 2'(exp_rnd), {"R8 ", tag}, rounds, exp_rnd);
        wait_idle();
        chk(closed && !err, {"R7 closed ", tag}, closed, 1);
        chk(hop_cnt == 16'(exp_k), {"R7 hops ", tag}, hop_cnt, exp_k);
        chk(end_col == 8'(c) && end_row == 8'(r), {"R7 tile ", tag}, end_col, c);
    endtask

    task automatic t_ignore_start();
        int exp_k;
        exp_k = ref_close(20, 1'b0, 60);
        launch(20, 7, 2'b00);
        @(negedge clk); @(negedge clk);
        start_col = 8'd90; start_row = 8'd3; start_dir = 2'b11; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(hop_cnt == 3 && dir[1] == 1'b0, "R9 no restart", hop_cnt, 3);
        wait_idle();
        chk(closed && hop_cnt == 16'(exp_k) && end_col == 20, "R9 walk intact", hop_cnt, exp_k);
    endtask

    task automatic t_abort();
        launch(30, 30, 2'b01);
        @(negedge clk); @(negedge clk);
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk(!busy && !closed && !err, "R10 stopped", {busy, closed, err}, 0);
        chk(hop_cnt == 2, "R10 count frozen", hop_cnt, 2);
        @(negedge clk);
        chk(hop_cnt == 2 && !busy, "R10 stays idle", hop_cnt, 2);
    endtask

    task automatic t_budget();
        hop_limit = 16'd5;
        launch(20, 7, 2'b00);
        wait_idle();
        chk(err && !closed, "R11 err", err, 1);
        chk(hop_cnt == 5, "R11 count", hop_cnt, 5);
        @(negedge clk);
        hop_limit = 16'hFFFF;
        launch(20, 7, 2'b00);
        chk(!err && busy, "R6 restart clears", err, 0);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain_hop();
        t_low_fold();
        t_high_fold();
        t_close(20, 7, 2'b00, 60, 3, "m60 left");
        lim_m = 8'd62;
        @(negedge clk);
        t_close(11, 40, 2'b01, 62, 1, "m62 right");
        lim_m = 8'd60;
        @(negedge clk);
        t_close(33, 10, 2'b11, 127, 3, "n127 up");
        t_ignore_start();
        t_abort();
        t_budget();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule